// File: doc/BRIEF.md
# Match-Action Timer

This block is a free-running up-counter driven through a prescaler. A set of compare registers watches the count. Each compare channel can act independently when the count reaches its value. It can flag an interrupt, return the count to zero or halt the counter, in any combination. It can also drive its own output pin high, low, invert it or leave it alone. Capture channels copy the count into a register when their input pin shows a selected edge. The default build is 32 bits wide, with four compare channels and two capture channels. A 16-bit build is the same RTL with `WIDTH` set to 16.

Software reaches the block through a flat register bus. A write happens on the clock edge at which `regWe` is high. Read data is combinational from `regAddr`. The address map with the defaults is:

| Address | Register |
|---|---|
| 0 | control |
| 1 | prescale limit |
| 2 | count |
| 3 | prescale count |
| 4..7 | compare values |
| 8 | compare action |
| 9 | output action |
| 10 | output state |
| 11 | capture edge select |
| 12..13 | captured values |
| 14 | flags |

A "tick" is an enabled clock edge at which the prescale count equals the prescale limit. A compare channel fires on a tick at which the count equals its compare value.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset, every register reads 0, `matchOut` is 0 and `irq` is 0.
- R2: With control bit 0 (run) set and control bit 1 clear, the prescale count steps once per clock and wraps to 0 after reaching the limit. The count rises by one at each wrap, so after K enabled edges with limit P the count is floor(K/(P+1)) and the prescale count is K mod (P+1). With run clear, both hold.
- R3: In the compare action register, bit 3c enables channel c's flag. When channel c fires with its flag enabled, flag bit c is set and `irq` goes high. A channel with its flag disabled sets no flag. Flags are sticky. Writing 1 to a flag bit clears only that bit, and a new event in the same cycle wins over the clear.
- R4: Bit 3c+1 enables reset for channel c. When channel c fires with reset enabled, the count becomes 0 instead of advancing, giving a period of M+1 ticks for compare value M.
- R5: Bit 3c+2 enables stop for channel c. When channel c fires with stop enabled and reset disabled, the count holds at the compare value and control bit 0 reads 0.
- R6: When channel c fires with both reset and stop enabled, the count becomes 0, holds there, and the run bit reads 0.
- R7: Bits [2c+1:2c] of the output action register select what channel c's output does when the channel fires: 0 holds, 1 drives low, 2 drives high, 3 inverts. Writing the output state register sets all outputs directly, and `matchOut` mirrors it.
- R8: Bits [2k+1:2k] of the capture edge select register choose the edges for capture channel k. Bit 2k selects rising edges and bit 2k+1 selects falling edges. On a selected edge of the synchronised `capIn[k]`, the count is stored in captured value k and flag bit NUM_MATCH+k (4+k by default) is set. Unselected edges change nothing.
- R9: A write to the count register loads the count and clears the prescale count. While control bit 1 is set, the count and the prescale count are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| capIn | input | 2 | Capture input pins |
| matchOut | output | 4 | Compare output pins |
| irq | output | 1 | High while any flag is set |

## Verification
The assertions take for granted that `capIn` is asynchronous to nothing: it is treated as an ordinary level that passes two sync flops. They also take for granted that software never writes the count register in the same cycle in which a reset or stop compare would fire. The stimulus respects this. The counter is halted before each count load, capture pin changes are spaced several clocks apart, and compare runs are started from a known count with a known prescale limit. That way every tick and firing edge can be counted exactly.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic pcInc;
    logic pcClr;
    logic tcInc;
    logic tcClr;
    logic tcLoad;
  } tmrStb_t;

  typedef enum logic [1:0] {
    OA_HOLD   = 2'd0,
    OA_CLEAR  = 2'd1,
    OA_SET    = 2'd2,
    OA_TOGGLE = 2'd3
  } outAct_e;
endpackage

// File: rtl/tmr_dp.sv
`timescale 1ns/1ps
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int NUM_CAP = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  tmrStb_t                        stb,
  input  logic [WIDTH-1:0]               loadVal,
  input  logic [2*NUM_CAP-1:0]           capCfg,
  input  logic [NUM_CAP-1:0]             capIn,
  output logic [WIDTH-1:0]               tc,
  output logic [WIDTH-1:0]               pc,
  output logic [NUM_CAP-1:0][WIDTH-1:0]  capVal,
  output logic [NUM_CAP-1:0]             capEvt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tc <= '0;
      pc <= '0;
    end else begin
      if (stb.tcLoad)     tc <= loadVal;
      else if (stb.tcClr) tc <= '0;
      else if (stb.tcInc) tc <= tc + 1'b1;
      if (stb.pcClr)      pc <= '0;
      else if (stb.pcInc) pc <= pc + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
    logic syncA, syncB, prevB;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        prevB <= 1'b0;
        capVal[k] <= '0;
      end else begin
        syncA <= capIn[k];
        syncB <= syncA;
        prevB <= syncB;
        if (capEvt[k]) capVal[k] <= tc;
      end
    end
    assign capEvt[k] = (syncB & ~prevB & capCfg[2*k]) |
                       (~syncB & prevB & capCfg[2*k+1]);

    // R8: a captured value moves only on a selected edge
    a_r8_cap_only_on_edge: assert property (@(posedge clk) disable iff (!rstN)
      !capEvt[k] |=> $stable(capVal[k]));
  end

  // R9: a load lands in the count on the next edge
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rstN)
    stb.tcLoad |=> tc == $past(loadVal));

  // R2: with no strobe the count holds
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.tcLoad && !stb.tcClr && !stb.tcInc) |=> $stable(tc));

endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [WIDTH-1:0]               regWdata,
  output logic [WIDTH-1:0]               regRdata,
  input  logic [WIDTH-1:0]               tc,
  input  logic [WIDTH-1:0]               pc,
  input  logic [NUM_CAP-1:0][WIDTH-1:0]  capVal,
  input  logic [NUM_CAP-1:0]             capEvt,
  output tmrStb_t                        stb,
  output logic [WIDTH-1:0]               loadVal,
  output logic [2*NUM_CAP-1:0]           capCfg,
  output logic [NUM_MATCH-1:0]           matchOut,
  output logic                           irq
);
  localparam int NFLAG = NUM_MATCH + NUM_CAP;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PSC   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PCNT  = ADDR_W'(3);
  localparam int               A_MATCH = 4;
  localparam logic [ADDR_W-1:0] A_MACT  = ADDR_W'(A_MATCH + NUM_MATCH);
  localparam logic [ADDR_W-1:0] A_OACT  = ADDR_W'(A_MATCH + NUM_MATCH + 1);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(A_MATCH + NUM_MATCH + 2);
  localparam logic [ADDR_W-1:0] A_CCFG  = ADDR_W'(A_MATCH + NUM_MATCH + 3);
  localparam int               A_CAP   = A_MATCH + NUM_MATCH + 4;
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(A_CAP + NUM_CAP);

  logic                     runEn, holdClr;
  logic [WIDTH-1:0]         pscLimit;
  logic [WIDTH-1:0]         matchVal [NUM_MATCH];
  logic [3*NUM_MATCH-1:0]   matchAct;
  logic [2*NUM_MATCH-1:0]   outAct;
  logic [NUM_MATCH-1:0]     outState;
  logic [2*NUM_CAP-1:0]     capCfgR;
  logic [NFLAG-1:0]         flags;

  logic wrCtl, wrCnt, wrOut, wrFlags, tick, anyRst, anyStop;
  logic [NUM_MATCH-1:0] matchEvt, irqMask, rstMask, stopMask;

  assign wrCtl   = regWe && regAddr == A_CTRL;
  assign wrCnt   = regWe && regAddr == A_CNT;
  assign wrOut   = regWe && regAddr == A_OUT;
  assign wrFlags = regWe && regAddr == A_FLAGS;
  assign tick    = runEn && !holdClr && !wrCnt && pc == pscLimit;

  always_comb begin
    for (int c = 0; c < NUM_MATCH; c++) begin
      irqMask[c]  = matchAct[3*c];
      rstMask[c]  = matchAct[3*c+1];
      stopMask[c] = matchAct[3*c+2];
      matchEvt[c] = tick && tc == matchVal[c];
    end
  end
  assign anyRst  = |(matchEvt & rstMask);
  assign anyStop = |(matchEvt & stopMask);

  always_comb begin
    stb        = '0;
    stb.tcLoad = wrCnt;
    stb.tcClr  = holdClr || anyRst;
    stb.tcInc  = tick && !anyStop;
    stb.pcClr  = wrCnt || holdClr || tick;
    stb.pcInc  = runEn;
  end
  assign loadVal  = regWdata;
  assign capCfg   = capCfgR;
  assign matchOut = outState;
  assign irq      = |flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      holdClr  <= 1'b0;
      pscLimit <= '0;
      matchAct <= '0;
      outAct   <= '0;
      outState <= '0;
      capCfgR  <= '0;
      flags    <= '0;
      for (int c = 0; c < NUM_MATCH; c++) matchVal[c] <= '0;
    end else begin
      if (wrCtl) begin
        runEn   <= regWdata[0];
        holdClr <= regWdata[1];
      end else if (anyStop) begin
        runEn <= 1'b0;
      end
      if (regWe && regAddr == A_PSC)  pscLimit <= regWdata;
      if (regWe && regAddr == A_MACT) matchAct <= regWdata[3*NUM_MATCH-1:0];
      if (regWe && regAddr == A_OACT) outAct   <= regWdata[2*NUM_MATCH-1:0];
      if (regWe && regAddr == A_CCFG) capCfgR  <= regWdata[2*NUM_CAP-1:0];
      for (int c = 0; c < NUM_MATCH; c++)
        if (regWe && regAddr == ADDR_W'(A_MATCH + c)) matchVal[c] <= regWdata;
      if (wrOut) outState <= regWdata[NUM_MATCH-1:0];
      else begin
        for (int c = 0; c < NUM_MATCH; c++) begin
          if (matchEvt[c]) begin
            case (outAct_e'(outAct[2*c +: 2]))
              OA_CLEAR:  outState[c] <= 1'b0;
              OA_SET:    outState[c] <= 1'b1;
              OA_TOGGLE: outState[c] <= ~outState[c];
              default:   ;
            endcase
          end
        end
      end
      flags <= (flags & ~(wrFlags ? regWdata[NFLAG-1:0] : '0)) |
               {capEvt, matchEvt & irqMask};
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:  regRdata = WIDTH'({holdClr, runEn});
      A_PSC:   regRdata = pscLimit;
      A_CNT:   regRdata = tc;
      A_PCNT:  regRdata = pc;
      A_MACT:  regRdata = WIDTH'(matchAct);
      A_OACT:  regRdata = WIDTH'(outAct);
      A_OUT:   regRdata = WIDTH'(outState);
      A_CCFG:  regRdata = WIDTH'(capCfgR);
      A_FLAGS: regRdata = WIDTH'(flags);
      default: ;
    endcase
    for (int c = 0; c < NUM_MATCH; c++)
      if (regAddr == ADDR_W'(A_MATCH + c)) regRdata = matchVal[c];
    for (int k = 0; k < NUM_CAP; k++)
      if (regAddr == ADDR_W'(A_CAP + k)) regRdata = capVal[k];
  end

  // R5: a stop firing drops the run bit
  a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    (anyStop && !wrCtl) |=> !runEn);

  // R4: a reset firing leaves the count at zero
  a_r4_reset_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> tc == '0);

  // R3: flags never fall without a clear write
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlags |=> ($past(flags) & ~flags) == '0);

  // R7: outputs move only on a firing or a direct write
  a_r7_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt == '0 && !wrOut) |=> $stable(matchOut));

  for (genvar c = 0; c < NUM_MATCH; c++) begin : g_flagchk
    // R3: an enabled firing raises its flag
    a_r3_flag_on_fire: assert property (@(posedge clk) disable iff (!rstN)
      (matchEvt[c] && irqMask[c]) |=> flags[c]);
  end

endmodule

// File: rtl/tmr_match_unit.sv
`timescale 1ns/1ps
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WIDTH-1:0]     regWdata,
  output logic [WIDTH-1:0]     regRdata,
  input  logic [NUM_CAP-1:0]   capIn,
  output logic [NUM_MATCH-1:0] matchOut,
  output logic                 irq
);
  tmrStb_t                       stb;
  logic [WIDTH-1:0]              tc, pc, loadVal;
  logic [NUM_CAP-1:0][WIDTH-1:0] capVal;
  logic [NUM_CAP-1:0]            capEvt;
  logic [2*NUM_CAP-1:0]          capCfg;

  tmr_ctrl #(.WIDTH(WIDTH), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .tc(tc), .pc(pc), .capVal(capVal), .capEvt(capEvt),
    .stb(stb), .loadVal(loadVal), .capCfg(capCfg), .matchOut(matchOut), .irq(irq)
  );

  tmr_dp #(.WIDTH(WIDTH), .NUM_CAP(NUM_CAP)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadVal), .capCfg(capCfg),
    .capIn(capIn), .tc(tc), .pc(pc), .capVal(capVal), .capEvt(capEvt)
  );
endmodule

// File: tb/test_tmr_match_unit.sv
`timescale 1ns/1ps
module test_tmr_match_unit;
  localparam int A_CTRL = 0, A_PSC = 1, A_CNT = 2, A_PCNT = 3, A_M0 = 4;
  localparam int A_MACT = 8, A_OACT = 9, A_OUT = 10, A_CCFG = 11, A_CAP0 = 12, A_FLAGS = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  capIn = '0;
  logic [3:0]  matchOut;
  logic        irq;
  logic        rdStrobe = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 register, 1 matchOut, 2 irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  tmr_match_unit i_tmr_match_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .capIn(capIn), .matchOut(matchOut), .irq(irq)
  );

  // monitor: compare each observation against the queued expectation
  always @(negedge clk) begin
    if (rdStrobe) begin
      item_t it;
      logic [31:0] act;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: observation with empty queue");
      end else begin
        it = sb.pop_front();
        case (it.kind)
          1:       act = 32'(matchOut);
          2:       act = 32'(irq);
          default: act = regRdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    regAddr = 4'(a); regWdata = d; regWe = 1'b1;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_obs(input int kind, input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    regAddr = 4'(a); rdStrobe = 1'b1;
    @(posedge clk); #1;
    rdStrobe = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    expect_obs(0, a, e, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, 0, "R1 control");
    rd(A_CNT, 0, "R1 count");
    rd(A_FLAGS, 0, "R1 flags");
    expect_obs(1, 0, 0, "R1 matchOut");
    expect_obs(2, 0, 0, "R1 irq");

    // R2 prescale: limit 2, 10 enabled edges -> count 3, prescale 1
    wr(A_PSC, 2);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(9);
    wr(A_CTRL, 0);
    rd(A_CNT, 3, "R2 count after 10 edges");
    rd(A_PCNT, 1, "R2 prescale after 10 edges");
    rd(A_FLAGS, 0, "R3 no flag without enable");
    idle(3);
    rd(A_CNT, 3, "R2 holds when stopped");

    // R9 hold-clear bit and count load
    wr(A_CTRL, 3);
    idle(4);
    rd(A_CNT, 0, "R9 hold clears count");
    rd(A_PCNT, 0, "R9 hold clears prescale");
    wr(A_CTRL, 0);
    wr(A_CNT, 32'hABCD);
    rd(A_CNT, 32'hABCD, "R9 count load");

    // R4 reset + flag on channel 0, value 3, 10 edges -> 10 mod 4 = 2
    wr(A_PSC, 0);
    wr(A_M0, 3);
    wr(A_MACT, 32'h3);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(9);
    wr(A_CTRL, 0);
    rd(A_CNT, 2, "R4 wrap period");
    rd(A_FLAGS, 1, "R3 flag set");
    expect_obs(2, 0, 1, "R3 irq high");
    wr(A_FLAGS, 1);
    rd(A_FLAGS, 0, "R3 write-one clear");
    expect_obs(2, 0, 0, "R3 irq low");

    // R5 stop only on channel 1, value 5
    wr(A_MACT, 32'h20);
    wr(A_M0 + 1, 5);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(19);
    rd(A_CTRL, 0, "R5 run cleared");
    rd(A_CNT, 5, "R5 holds at compare");
    rd(A_FLAGS, 0, "R3 stop without flag");

    // R6 reset + stop + flag on channel 2, value 4
    wr(A_MACT, 32'h1C0);
    wr(A_M0 + 2, 4);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(15);
    rd(A_CTRL, 0, "R6 run cleared");
    rd(A_CNT, 0, "R6 zero and held");
    rd(A_FLAGS, 4, "R6 flag of channel 2");
    wr(A_FLAGS, 32'h3F);

    // R7 output actions: ch0 clear, ch1 set, ch2 toggle, ch3 hold
    wr(A_MACT, 0);
    wr(A_OACT, 32'h39);
    wr(A_OUT, 32'h5);
    for (int c = 0; c < 4; c++) wr(A_M0 + c, 1);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(4);
    wr(A_CTRL, 0);
    rd(A_OUT, 2, "R7 output state after one firing");
    expect_obs(1, 0, 2, "R7 matchOut after one firing");
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    idle(4);
    wr(A_CTRL, 0);
    expect_obs(1, 0, 6, "R7 matchOut after second firing");

    // R8 capture: ch0 rising, ch1 falling
    wr(A_CCFG, 32'h9);
    wr(A_CNT, 32'h55);
    capIn = 2'b11;
    idle(4);
    rd(A_CAP0, 32'h55, "R8 ch0 rising capture");
    rd(A_CAP0 + 1, 0, "R8 ch1 ignores rising");
    rd(A_FLAGS, 32'h10, "R8 ch0 flag");
    wr(A_CNT, 32'h66);
    capIn = 2'b00;
    idle(4);
    rd(A_CAP0, 32'h55, "R8 ch0 ignores falling");
    rd(A_CAP0 + 1, 32'h66, "R8 ch1 falling capture");
    rd(A_FLAGS, 32'h30, "R8 both flags");
    wr(A_CCFG, 32'h3);
    wr(A_CNT, 32'h77);
    capIn = 2'b01;
    idle(4);
    rd(A_CAP0, 32'h77, "R8 both-edge rising");
    wr(A_CNT, 32'h88);
    capIn = 2'b00;
    idle(4);
    rd(A_CAP0, 32'h88, "R8 both-edge falling");
    wr(A_FLAGS, 32'h10);
    rd(A_FLAGS, 32'h20, "R3 selective clear");

    idle(2);
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    summary();
  end
endmodule